// File: doc/BRIEF.md
# Table-Driven Position-Automaton Regex Matcher

This block runs a position automaton (one state per symbol position of a compiled regular expression) over a stream of symbol-class IDs. Its state is a bit vector with one bit per automaton state. For every symbol it forms the union of the successor sets of all active states. It then keeps only the states that the incoming class is allowed to enter. Successor sets, per-class entry masks and the accepting-state mask all live in small internal memories, so the regular expression changes by rewriting tables, not logic.

The active-state vector is cut into equal groups. Each group addresses its own table, and each entry of that table holds the precomputed union of successor sets for one bit pattern of the group. All group tables and the entry table are read in the same cycle. The block therefore takes one symbol every two cycles, whatever the number of active states. Input bytes are assumed to be mapped to class IDs upstream, so letters that must match without regard to case already share one ID. A multi-line mode puts the automaton back at its start state whenever a line break arrives. This supports patterns anchored to the beginning of a line.

Software loads the tables through a write port while the engine is idle. It pulses start, streams classes and pulses end-of-input. It then reads the one-cycle accept flag and the sticky match vector.

Top module: `gnfa_matcher`

## Requirements
- R1: After synchronous reset, `busy_o`, `accept_o` and `match_o` are all zero.
- R2: A `start_i` pulse clears `match_o` and sets the state vector to state 0 alone. The first symbol after start is therefore evaluated from state 0 only.
- R3: A symbol offered while `busy_o` is low is taken, and `busy_o` is high during exactly the next cycle. A symbol offered while `busy_o` is high is ignored.
- R4: For each symbol taken with class c, the new state vector is the OR of the successor sets of all active states, ANDed with the entry mask stored for class c. This holds with active states in several groups at once.
- R5: `match_o` is the OR, over all steps since start, of the new state vector ANDed with the accepting mask. It changes only at the edge that ends a busy cycle.
- R6: One cycle after an `eoi_i` pulse given while not busy, `accept_o` equals the OR of all bits of `match_o`. It is low in every other cycle, and an `eoi_i` given while busy is ignored.
- R7: When `multiline_i` is high, a symbol taken with `sym_newline_i` high sets the state vector to state 0 alone and ignores its class. When `multiline_i` is low, the newline flag has no effect.
- R8: `wr_sel_i` selects the table. Codes 0 to 3 select the successor table of group g, addressed by the group's 4-bit pattern, where bit i stands for state 4g+i. Code 4 selects the entry table, addressed by class ID. Code 5 selects the accepting mask, and its address is ignored. A write is ignored while `busy_o` is high or while `sym_valid_i` is high.
- R9: When `start_i` and `sym_valid_i` are high in the same cycle, the start wins and the symbol is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start/clear pulse |
| sym_valid_i | input | 1 | Symbol-class ID valid |
| sym_class_i | input | CLASS_W | Symbol-class ID |
| sym_newline_i | input | 1 | Symbol is a line break |
| multiline_i | input | 1 | Multi-line mode enable |
| eoi_i | input | 1 | End-of-input pulse |
| wr_en_i | input | 1 | Table write enable |
| wr_sel_i | input | 3 | Table select (0-3 group, 4 entry, 5 accepting) |
| wr_addr_i | input | ADDR_W | Table address |
| wr_data_i | input | N_STATES | Table write data |
| busy_o | output | 1 | Second cycle of a symbol step in progress |
| match_o | output | N_STATES | Sticky accepting-state register |
| accept_o | output | 1 | Accept result, valid one cycle after end-of-input |

## Verification
The bench builds the block with its default values: 16 states in four groups of 4 and 4-bit class IDs. With these values every one of the 64 group-table entries, all 16 class entries and the accepting mask can be loaded in full. Tables filled from a pseudo-random successor relation keep many states active across all four groups at once. The parallel group union is checked against a bench model at every step. A two-position anchored pattern is then used to make dropped symbols, line-break resets, ignored writes and start priority each visible in `match_o`.

// File: rtl/gnfa_pkg.sv
package gnfa_pkg;
  // Width of the table select field and its fixed codes.
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_ENTER = 3'd4;
  localparam logic [SEL_W-1:0] SEL_FINAL = 3'd5;

  // Number of group tables the select field can address (codes 0..3).
  localparam int MAX_GROUPS = 4;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/gnfa_table_ram.sv
// Single-port-write, single-port-read memory with registered read data,
// written so that block RAM can be inferred.
module gnfa_table_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/gnfa_step_ctrl.sv
// Two-phase step control: symbol acceptance, busy phase, write gating,
// line-break pending flag and the accept pulse.
module gnfa_step_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic sym_valid_i,
  input  logic sym_newline_i,
  input  logic multiline_i,
  input  logic eoi_i,
  input  logic wr_en_i,
  input  logic any_match_i,
  output logic busy_o,
  output logic wr_ok_o,
  output logic nl_pend_o,
  output logic accept_o
);
  logic busy_q, nl_q, acc_q;
  logic take;

  assign take    = sym_valid_i & ~busy_q & ~start_i;
  assign wr_ok_o = wr_en_i & ~busy_q & ~sym_valid_i;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      busy_q <= 1'b0;
      nl_q   <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      busy_q <= take;
      nl_q   <= take & multiline_i & sym_newline_i;
      acc_q  <= (eoi_i & ~busy_q) ? any_match_i : 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign nl_pend_o = nl_q;
  assign accept_o  = acc_q;
endmodule

// File: rtl/gnfa_state_core.sv
// Active-state vector, accepting mask and sticky match register. Combines
// the group-table read data with the entry mask in the commit cycle.
module gnfa_state_core #(
  parameter int N_STATES = 16,
  parameter int N_GROUPS = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start_i,
  input  logic                               commit_i,
  input  logic                               nl_pend_i,
  input  logic [N_GROUPS-1:0][N_STATES-1:0]  grp_rd_i,
  input  logic [N_STATES-1:0]                enter_rd_i,
  input  logic                               final_we_i,
  input  logic [N_STATES-1:0]                final_wd_i,
  output logic [N_STATES-1:0]                state_o,
  output logic [N_STATES-1:0]                match_o
);
  localparam logic [N_STATES-1:0] INIT_VEC = N_STATES'(1);

  logic [N_STATES-1:0] state_q, match_q, final_q;
  logic [N_STATES-1:0] follow_or, nxt;

  always_comb begin
    follow_or = '0;
    for (int g = 0; g < N_GROUPS; g++) follow_or = follow_or | grp_rd_i[g];
    nxt = nl_pend_i ? INIT_VEC : (follow_or & enter_rd_i);
  end

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      state_q <= INIT_VEC;
      match_q <= '0;
    end else if (commit_i) begin
      state_q <= nxt;
      match_q <= match_q | (nxt & final_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             final_q <= '0;
    else if (final_we_i) final_q <= final_wd_i;
  end

  assign state_o = state_q;
  assign match_o = match_q;
endmodule

// File: rtl/gnfa_matcher.sv
// Top level: group successor tables, entry table, control and state core.
module gnfa_matcher
  import gnfa_pkg::*;
#(
  parameter int N_STATES = 16,
  parameter int N_GROUPS = 4,
  parameter int CLASS_W  = 4,
  localparam int GROUP_W = N_STATES / N_GROUPS,
  localparam int ADDR_W  = max_int(GROUP_W, CLASS_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                sym_valid_i,
  input  logic [CLASS_W-1:0]  sym_class_i,
  input  logic                sym_newline_i,
  input  logic                multiline_i,
  input  logic                eoi_i,
  input  logic                wr_en_i,
  input  logic [SEL_W-1:0]    wr_sel_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [N_STATES-1:0] wr_data_i,
  output logic                busy_o,
  output logic [N_STATES-1:0] match_o,
  output logic                accept_o
);
  logic                              wr_ok, nl_pend, busy;
  logic [N_STATES-1:0]               state_vec, enter_rd, match_vec;
  logic [N_GROUPS-1:0][N_STATES-1:0] grp_rd;

  gnfa_step_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .sym_valid_i  (sym_valid_i),
    .sym_newline_i(sym_newline_i),
    .multiline_i  (multiline_i),
    .eoi_i        (eoi_i),
    .wr_en_i      (wr_en_i),
    .any_match_i  (|match_vec),
    .busy_o       (busy),
    .wr_ok_o      (wr_ok),
    .nl_pend_o    (nl_pend),
    .accept_o     (accept_o)
  );

  // One successor table per group, addressed by that group's state bits.
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic grp_we;
    assign grp_we = wr_ok && (wr_sel_i == SEL_W'(g));
    gnfa_table_ram #(.ADDR_W(GROUP_W), .DATA_W(N_STATES)) u_grp_ram (
      .clk  (clk),
      .we   (grp_we),
      .waddr(wr_addr_i[GROUP_W-1:0]),
      .wdata(wr_data_i),
      .raddr(state_vec[g*GROUP_W +: GROUP_W]),
      .rdata(grp_rd[g])
    );
  end

  logic enter_we;
  assign enter_we = wr_ok && (wr_sel_i == SEL_ENTER);

  gnfa_table_ram #(.ADDR_W(CLASS_W), .DATA_W(N_STATES)) u_enter_ram (
    .clk  (clk),
    .we   (enter_we),
    .waddr(wr_addr_i[CLASS_W-1:0]),
    .wdata(wr_data_i),
    .raddr(sym_class_i),
    .rdata(enter_rd)
  );

  gnfa_state_core #(.N_STATES(N_STATES), .N_GROUPS(N_GROUPS)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .commit_i  (busy),
    .nl_pend_i (nl_pend),
    .grp_rd_i  (grp_rd),
    .enter_rd_i(enter_rd),
    .final_we_i(wr_ok && (wr_sel_i == SEL_FINAL)),
    .final_wd_i(wr_data_i),
    .state_o   (state_vec),
    .match_o   (match_vec)
  );

  assign busy_o  = busy;
  assign match_o = match_vec;
endmodule

// File: rtl/gnfa_matcher_chk.sv
module gnfa_matcher_chk #(
  parameter int N_STATES = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                sym_valid_i,
  input logic                eoi_i,
  input logic                busy_o,
  input logic [N_STATES-1:0] match_o,
  input logic                accept_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && !accept_o && match_o == '0));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (match_o == '0 && !busy_o));

  // R3
  busy_single_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !busy_o);

  // R3
  busy_on_take_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_valid_i && !busy_o && !start_i) |=> busy_o);

  // R5
  match_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(match_o));

  // R5
  match_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !start_i) |=> ((match_o & $past(match_o)) == $past(match_o)));

  // R6
  accept_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !eoi_i |=> !accept_o);

  // R6
  accept_value_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !busy_o && !start_i) |=> (accept_o == (|$past(match_o))));
endmodule

bind gnfa_matcher gnfa_matcher_chk #(.N_STATES(N_STATES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .sym_valid_i(sym_valid_i),
  .eoi_i      (eoi_i),
  .busy_o     (busy_o),
  .match_o    (match_o),
  .accept_o   (accept_o)
);

// File: tb/gnfa_matcher_tb.sv
`timescale 1ns/1ps
module gnfa_matcher_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 0, sym_valid_i = 0, sym_newline_i = 0;
  logic        multiline_i = 0, eoi_i = 0, wr_en_i = 0;
  logic [3:0]  sym_class_i = '0;
  logic [2:0]  wr_sel_i = '0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        busy_o, accept_o;
  logic [15:0] match_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] fol [16];
  logic [15:0] ent [16];
  logic [15:0] fin;
  logic [15:0] mstate, mmatch;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2.5 clk = ~clk;

  gnfa_matcher u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sym_valid_i(sym_valid_i),
    .sym_class_i(sym_class_i), .sym_newline_i(sym_newline_i),
    .multiline_i(multiline_i), .eoi_i(eoi_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .busy_o(busy_o), .match_o(match_o), .accept_o(accept_o)
  );

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  function automatic logic [15:0] grp_val(input int g, input logic [3:0] p);
    logic [15:0] v = '0;
    for (int i = 0; i < 4; i++) if (p[i]) v = v | fol[g*4+i];
    return v;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [3:0] addr, input logic [15:0] data);
    @(negedge clk);
    wr_en_i = 1; wr_sel_i = sel; wr_addr_i = addr; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic load_all();
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < 16; p++) wr(3'(g), 4'(p), grp_val(g, 4'(p)));
    for (int c = 0; c < 16; c++) wr(3'd4, 4'(c), ent[c]);
    wr(3'd5, 4'hA, fin);
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    mstate = 16'h0001; mmatch = '0;
  endtask

  task automatic model(input logic [3:0] cls, input logic nl);
    logic [15:0] nx = '0;
    if (multiline_i && nl) nx = 16'h0001;
    else begin
      for (int s = 0; s < 16; s++) if (mstate[s]) nx = nx | fol[s];
      nx = nx & ent[cls];
    end
    mstate = nx;
    mmatch = mmatch | (nx & fin);
  endtask

  task automatic step(input logic [3:0] cls, input logic nl, input string req);
    @(negedge clk); sym_valid_i = 1; sym_class_i = cls; sym_newline_i = nl;
    @(negedge clk); sym_valid_i = 0; sym_newline_i = 0;
    chk("R3 busy after take", 16'(busy_o), 16'h1);
    @(negedge clk);
    model(cls, nl);
    chk(req, match_o, mmatch);
  endtask

  task automatic eoi_chk(input logic exp, input string req);
    @(negedge clk); eoi_i = 1;
    @(negedge clk); eoi_i = 0;
    chk(req, 16'(accept_o), 16'(exp));
    @(negedge clk);
    chk("R6 accept one cycle", 16'(accept_o), 16'h0);
  endtask

  // Anchored two-position pattern: class 1 then class 2, state 2 accepts.
  task automatic setup_ab();
    for (int s = 0; s < 16; s++) fol[s] = '0;
    for (int c = 0; c < 16; c++) ent[c] = '0;
    fol[0] = 16'h0002; fol[1] = 16'h0004;
    ent[1] = 16'h0002; ent[2] = 16'h0004;
    fin    = 16'h0004;
    load_all();
  endtask

  task automatic t_reset();
    chk("R1 busy", 16'(busy_o), 16'h0);
    chk("R1 accept", 16'(accept_o), 16'h0);
    chk("R1 match", match_o, 16'h0);
  endtask

  task automatic t_basic();
    setup_ab();
    do_start();
    chk("R2 match cleared", match_o, 16'h0);
    step(4'd1, 1'b0, "R4 first step");
    step(4'd2, 1'b0, "R5 match after ab");
    chk("R5 match bit", match_o, 16'h0004);
    eoi_chk(1'b1, "R6 accept high");
    do_start();
    chk("R2 start clears match", match_o, 16'h0);
    step(4'd2, 1'b0, "R4 b from start");
    step(4'd1, 1'b0, "R4 a after b");
    eoi_chk(1'b0, "R6 accept low");
  endtask

  task automatic t_busy_hold();
    do_start();
    @(negedge clk); sym_valid_i = 1; sym_class_i = 4'd1;
    @(negedge clk);
    chk("R3 busy held", 16'(busy_o), 16'h1);
    @(negedge clk);
    chk("R3 busy drops", 16'(busy_o), 16'h0);
    sym_valid_i = 0;
    model(4'd1, 1'b0);
    step(4'd2, 1'b0, "R3 second offer ignored");
    chk("R3 match after hold", match_o, 16'h0004);
    // eoi in busy cycle is ignored
    do_start();
    step(4'd1, 1'b0, "R4 a");
    @(negedge clk); sym_valid_i = 1; sym_class_i = 4'd2;
    @(negedge clk); sym_valid_i = 0; eoi_i = 1;
    @(negedge clk); eoi_i = 0;
    model(4'd2, 1'b0);
    chk("R6 eoi while busy ignored", 16'(accept_o), 16'h0);
    chk("R5 match committed", match_o, 16'h0004);
  endtask

  task automatic t_newline();
    multiline_i = 1;
    do_start();
    step(4'd1, 1'b0, "R7 a");
    step(4'd2, 1'b1, "R7 newline resets");
    chk("R7 no match after newline", match_o, 16'h0);
    step(4'd1, 1'b0, "R7 a after reset");
    step(4'd2, 1'b0, "R7 b after reset");
    chk("R7 match on new line", match_o, 16'h0004);
    multiline_i = 0;
    do_start();
    step(4'd1, 1'b0, "R7 a single-line");
    step(4'd2, 1'b1, "R7 flag ignored");
    chk("R7 match with flag ignored", match_o, 16'h0004);
  endtask

  task automatic t_write_gate();
    do_start();
    @(negedge clk);
    sym_valid_i = 1; sym_class_i = 4'd1;
    wr_en_i = 1; wr_sel_i = 3'd5; wr_data_i = 16'h0000;
    @(negedge clk);
    sym_valid_i = 0;
    @(negedge clk);
    wr_en_i = 0;
    model(4'd1, 1'b0);
    step(4'd2, 1'b0, "R8 writes while valid or busy ignored");
    chk("R8 accepting mask kept", match_o, 16'h0004);
    wr(3'd5, 4'h3, 16'h0000);
    fin = 16'h0000;
    do_start();
    step(4'd1, 1'b0, "R8 a");
    step(4'd2, 1'b0, "R8 idle write applied");
    chk("R8 no match with empty mask", match_o, 16'h0000);
    wr(3'd5, 4'h0, 16'h0004);
    fin = 16'h0004;
  endtask

  task automatic t_start_prio();
    do_start();
    @(negedge clk); start_i = 1; sym_valid_i = 1; sym_class_i = 4'd1;
    @(negedge clk); start_i = 0; sym_valid_i = 0;
    chk("R9 symbol dropped (busy)", 16'(busy_o), 16'h0);
    mstate = 16'h0001; mmatch = '0;
    step(4'd2, 1'b0, "R9 b from start state");
    chk("R9 no match", match_o, 16'h0000);
  endtask

  task automatic t_random();
    for (int s = 0; s < 16; s++) fol[s] = 16'(next_rand()) & 16'(next_rand());
    fol[0] = fol[0] | 16'h0001;
    for (int c = 0; c < 16; c++) ent[c] = 16'(next_rand()) | 16'h0001;
    fin = 16'h8080;
    load_all();
    do_start();
    for (int k = 0; k < 40; k++) step(4'(next_rand()), 1'b0, "R4 multi-group union");
    eoi_chk(|mmatch, "R6 accept after random run");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy_hold();
    t_newline();
    t_write_gate();
    t_start_prio();
    t_random();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule